// File: doc/BRIEF.md
# Oversampled Asynchronous Frame Receiver

This block turns an asynchronous serial line into parallel words. A 16x oversampling tick comes from outside. The receiver confirms a start bit, samples each bit at its centre and assembles 7 or 8 data bits. The bits may arrive least or most significant first. An optional parity bit follows the data. In multiprocessor mode an address/data marker bit takes its place. One or two stop bits close the frame.

The completed word is held in a receive register with a full flag, which a one-cycle read strobe clears. Parity, framing and overrun errors and the received marker bit are reported alongside the word. A bus-idle flag tells software that the line has gone quiet after the last stop bit. The full flag rises at the first stop bit, so software can fetch the word while a second stop bit is still on the line. The idle flag waits until the final stop bit has ended.

Top module: `async_frame_rx`

## Requirements
- R1: After reset, rx_data is 0, rx_full, parity_err, frame_err, overrun and addr_bit are 0, and bus_idle is 1.
- R2: A start bit begins on a falling line edge while reception is enabled. It is accepted only if the line is still low 8 ticks later, at mid-bit. A shorter low pulse returns the receiver to waiting and changes no output.
- R3: Every bit after the start bit is sampled 16 ticks after the previous sample. The frame carries 8 data bits when cfg_eight_bits is 1 and 7 otherwise. In 7-bit mode rx_data[7] reads 0.
- R4: With cfg_msb_first at 0 the first data bit received lands in rx_data[0]. With cfg_msb_first at 1 the first bit received is the top data bit: rx_data[7] in 8-bit mode, rx_data[6] in 7-bit mode.
- R5: With cfg_parity_en at 1 and cfg_mp_mode at 0, one bit follows the data. For even parity (cfg_parity_odd at 0) it must equal the XOR of the data bits; for odd parity it must equal the inverse. A mismatch sets parity_err with the word.
- R6: With cfg_mp_mode at 1, one bit follows the data whatever cfg_parity_en says. Its value is reported on addr_bit and parity_err stays 0. Outside this mode addr_bit is 0.
- R7: frame_err is set when the first stop bit is sampled low. When cfg_two_stop is 1 it is also set when the second stop bit is sampled low. Otherwise it is 0 for the frame.
- R8: rx_full rises, and rx_data and parity_err update, at the sample of the first stop bit, also when two stop bits are configured.
- R9: A rd_strobe pulse clears rx_full and overrun. When a frame completes while rx_full is set and no read arrives in that cycle, overrun is set and the new word replaces the old one.
- R10: bus_idle falls when a start bit is accepted. It rises 8 ticks after the sample of the final stop bit, if no new start bit has been accepted by then. It stays low throughout the stop bits.
- R11: Dropping rx_enable during a frame lets that frame complete and be stored. While rx_enable is 0, no new start bit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit period |
| rx_in | input | 1 | Serial line, idle high |
| rx_enable | input | 1 | Permits new start bits |
| cfg_eight_bits | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_parity_en | input | 1 | Parity bit present and checked |
| cfg_parity_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_mp_mode | input | 1 | Multiprocessor mode, address/data bit after data |
| cfg_two_stop | input | 1 | 1: two stop bits checked |
| cfg_msb_first | input | 1 | 1: most significant data bit first |
| rd_strobe | input | 1 | One-cycle read of the received word |
| rx_data | output | 8 | Received word |
| rx_full | output | 1 | Word waiting to be read |
| parity_err | output | 1 | Parity mismatch in the held word |
| frame_err | output | 1 | A checked stop bit was low |
| overrun | output | 1 | A word was replaced before being read |
| addr_bit | output | 1 | Received address/data marker |
| bus_idle | output | 1 | Line quiet since the end of the last frame |

## Verification
The hardest window to reach is the second stop bit. The full flag must already be high there, while the idle flag is still low and any framing error from that bit is not yet visible. The bench reaches it by probing each frame eight clocks into the second stop bit, before that bit's sample point. A sweep of all 64 format settings does the same at three quarters of the first stop bit. The other hard case is a frame that is still arriving when reception is switched off. The bench drops the enable just after the start bit, then checks that the word still arrives and that the next frame is ignored.

// File: rtl/afr_pkg.sv
package afr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_EXTRA,
    ST_STOP1,
    ST_STOP2,
    ST_TAIL
  } rx_state_e;

  // Position in the word of the data bit received at arrival index idx.
  function automatic int bit_slot(input int idx, input logic msb_first, input int nbits);
    return msb_first ? (nbits - 1 - idx) : idx;
  endfunction

  // Expected parity bit for a word whose unused bits are zero.
  function automatic logic parity_of(input logic [7:0] w, input logic odd);
    return (^w) ^ odd;
  endfunction

endpackage

// File: rtl/afr_sync.sv
module afr_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic rx_s,
  output logic fall
);
  logic meta_q, line_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      line_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rx_in;
      line_q <= meta_q;
      prev_q <= line_q;
    end
  end

  assign rx_s = line_q;
  assign fall = prev_q & ~line_q;
endmodule

// File: rtl/afr_deframer.sv
module afr_deframer
  import afr_pkg::*;
#(
  parameter int OS_RATE = 16,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rx_s,
  input  logic          fall,
  input  logic          rx_enable,
  input  logic          cfg_eight_bits,
  input  logic          cfg_parity_en,
  input  logic          cfg_mp_mode,
  input  logic          cfg_two_stop,
  input  logic          cfg_msb_first,
  output logic [DW-1:0] word,
  output logic          extra_bit,
  output logic          start_ok,
  output logic          frame_done,
  output logic          stop2_done,
  output logic          idle_set,
  output logic          in_idle
);
  localparam int CW   = $clog2(OS_RATE);
  localparam int IW   = $clog2(DW + 1);
  localparam int SW   = $clog2(DW);
  localparam int HALF = OS_RATE / 2;
  localparam logic [CW-1:0] FULL_LAST = CW'(OS_RATE - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);

  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW-1:0] word_q;
  logic          extra_q;

  logic mid_hit, half_hit, new_start, has_extra, last_data;
  int   nbits;

  assign nbits     = cfg_eight_bits ? DW : DW - 1;
  assign has_extra = cfg_parity_en | cfg_mp_mode;
  assign last_data = (idx == IW'(nbits - 1));
  assign mid_hit   = os_tick && (cnt == FULL_LAST);
  assign half_hit  = os_tick && (cnt == HALF_LAST);
  assign new_start = fall && rx_enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      word_q  <= '0;
      extra_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (new_start) state <= ST_START;
        end
        ST_START: if (os_tick) begin
          if (cnt == HALF_LAST) begin
            cnt     <= '0;
            idx     <= '0;
            word_q  <= '0;
            extra_q <= 1'b0;
            state   <= rx_s ? ST_IDLE : ST_DATA;
          end else cnt <= cnt + 1'b1;
        end
        ST_DATA: if (os_tick) begin
          if (cnt == FULL_LAST) begin
            cnt <= '0;
            word_q[SW'(bit_slot(int'(idx), cfg_msb_first, nbits))] <= rx_s;
            if (last_data) state <= has_extra ? ST_EXTRA : ST_STOP1;
            else idx <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_EXTRA: if (os_tick) begin
          if (cnt == FULL_LAST) begin
            cnt     <= '0;
            extra_q <= rx_s;
            state   <= ST_STOP1;
          end else cnt <= cnt + 1'b1;
        end
        ST_STOP1: if (os_tick) begin
          if (cnt == FULL_LAST) begin
            cnt   <= '0;
            state <= cfg_two_stop ? ST_STOP2 : ST_TAIL;
          end else cnt <= cnt + 1'b1;
        end
        ST_STOP2: if (os_tick) begin
          if (cnt == FULL_LAST) begin
            cnt   <= '0;
            state <= ST_TAIL;
          end else cnt <= cnt + 1'b1;
        end
        ST_TAIL: begin
          if (new_start) begin
            cnt   <= '0;
            state <= ST_START;
          end else if (os_tick) begin
            if (cnt == HALF_LAST) state <= ST_IDLE;
            else cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Named events for the result register and the checker.
  assign word       = word_q;
  assign extra_bit  = extra_q;
  assign start_ok   = (state == ST_START) && half_hit && !rx_s;
  assign frame_done = (state == ST_STOP1) && mid_hit;
  assign stop2_done = (state == ST_STOP2) && mid_hit;
  assign idle_set   = ((state == ST_TAIL) && half_hit && !new_start) ||
                      ((state == ST_START) && half_hit && rx_s);
  assign in_idle    = (state == ST_IDLE);
endmodule

// File: rtl/afr_holding.sv
module afr_holding
  import afr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] word,
  input  logic          extra_bit,
  input  logic          rx_s,
  input  logic          start_ok,
  input  logic          frame_done,
  input  logic          stop2_done,
  input  logic          idle_set,
  input  logic          rd_strobe,
  input  logic          cfg_parity_en,
  input  logic          cfg_parity_odd,
  input  logic          cfg_mp_mode,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          parity_err,
  output logic          frame_err,
  output logic          overrun,
  output logic          addr_bit,
  output logic          bus_idle
);
  logic par_bad;
  assign par_bad = cfg_parity_en && !cfg_mp_mode &&
                   (extra_bit != parity_of(8'(word), cfg_parity_odd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_full    <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      overrun    <= 1'b0;
      addr_bit   <= 1'b0;
    end else if (frame_done) begin
      rx_data    <= word;
      rx_full    <= 1'b1;
      overrun    <= rx_full && !rd_strobe;
      parity_err <= par_bad;
      frame_err  <= !rx_s;
      addr_bit   <= cfg_mp_mode && extra_bit;
    end else begin
      if (rd_strobe) begin
        rx_full <= 1'b0;
        overrun <= 1'b0;
      end
      if (stop2_done && !rx_s) frame_err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bus_idle <= 1'b1;
    else if (start_ok) bus_idle <= 1'b0;
    else if (idle_set) bus_idle <= 1'b1;
  end
endmodule

// File: rtl/async_frame_rx.sv
module async_frame_rx #(
  parameter int OS_RATE = 16,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rx_in,
  input  logic          rx_enable,
  input  logic          cfg_eight_bits,
  input  logic          cfg_parity_en,
  input  logic          cfg_parity_odd,
  input  logic          cfg_mp_mode,
  input  logic          cfg_two_stop,
  input  logic          cfg_msb_first,
  input  logic          rd_strobe,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          parity_err,
  output logic          frame_err,
  output logic          overrun,
  output logic          addr_bit,
  output logic          bus_idle
);
  logic          rx_s, fall;
  logic [DW-1:0] word;
  logic          extra_bit, start_ok, frame_done, stop2_done, idle_set, in_idle;

  afr_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rx_in (rx_in),
    .rx_s  (rx_s),
    .fall  (fall)
  );

  afr_deframer #(.OS_RATE(OS_RATE), .DW(DW)) u_deframer (
    .clk            (clk),
    .rst_n          (rst_n),
    .os_tick        (os_tick),
    .rx_s           (rx_s),
    .fall           (fall),
    .rx_enable      (rx_enable),
    .cfg_eight_bits (cfg_eight_bits),
    .cfg_parity_en  (cfg_parity_en),
    .cfg_mp_mode    (cfg_mp_mode),
    .cfg_two_stop   (cfg_two_stop),
    .cfg_msb_first  (cfg_msb_first),
    .word           (word),
    .extra_bit      (extra_bit),
    .start_ok       (start_ok),
    .frame_done     (frame_done),
    .stop2_done     (stop2_done),
    .idle_set       (idle_set),
    .in_idle        (in_idle)
  );

  afr_holding #(.DW(DW)) u_holding (
    .clk            (clk),
    .rst_n          (rst_n),
    .word           (word),
    .extra_bit      (extra_bit),
    .rx_s           (rx_s),
    .start_ok       (start_ok),
    .frame_done     (frame_done),
    .stop2_done     (stop2_done),
    .idle_set       (idle_set),
    .rd_strobe      (rd_strobe),
    .cfg_parity_en  (cfg_parity_en),
    .cfg_parity_odd (cfg_parity_odd),
    .cfg_mp_mode    (cfg_mp_mode),
    .rx_data        (rx_data),
    .rx_full        (rx_full),
    .parity_err     (parity_err),
    .frame_err      (frame_err),
    .overrun        (overrun),
    .addr_bit       (addr_bit),
    .bus_idle       (bus_idle)
  );
endmodule

// File: rtl/afr_checker.sv
module afr_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_enable,
  input logic rd_strobe,
  input logic start_ok,
  input logic frame_done,
  input logic in_idle,
  input logic rx_full,
  input logic overrun,
  input logic bus_idle
);
  assert_full_at_stop1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rx_full);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !frame_done) |=> (!rx_full && !overrun));

  assert_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_full && !rd_strobe) |=> overrun);

  assert_busy_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> !bus_idle);

  assert_not_idle_at_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !bus_idle);

  assert_disabled_waits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && !rx_enable) |=> in_idle);
endmodule

bind async_frame_rx afr_checker u_afr_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_enable  (rx_enable),
  .rd_strobe  (rd_strobe),
  .start_ok   (start_ok),
  .frame_done (frame_done),
  .in_idle    (in_idle),
  .rx_full    (rx_full),
  .overrun    (overrun),
  .bus_idle   (bus_idle)
);

// File: tb/async_frame_rx_test.sv
module async_frame_rx_test;
  localparam int BIT = 32;  // clocks per bit: one tick every 2 clocks, 16 ticks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic rxl = 1'b1;
  logic en = 1'b1;
  logic c_eight = 1'b1, c_pen = 1'b0, c_odd = 1'b0, c_mp = 1'b0, c_two = 1'b0, c_msb = 1'b0;
  logic rd = 1'b0;
  logic [7:0] rx_data;
  logic rx_full, parity_err, frame_err, overrun, addr_bit, bus_idle;
  int n_checks = 0;
  int n_fail = 0;
  bit expect_rx = 1'b1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  async_frame_rx uut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rxl), .rx_enable(en),
    .cfg_eight_bits(c_eight), .cfg_parity_en(c_pen), .cfg_parity_odd(c_odd),
    .cfg_mp_mode(c_mp), .cfg_two_stop(c_two), .cfg_msb_first(c_msb),
    .rd_strobe(rd), .rx_data(rx_data), .rx_full(rx_full), .parity_err(parity_err),
    .frame_err(frame_err), .overrun(overrun), .addr_bit(addr_bit), .bus_idle(bus_idle)
  );

  initial forever begin
    @(negedge clk);
    os_tick = ~os_tick;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] masked(input logic [7:0] d);
    return c_eight ? d : {1'b0, d[6:0]};
  endfunction

  function automatic logic good_par(input logic [7:0] d);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(masked(d)[i]);
    return logic'(ones % 2) ^ c_odd;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic ext, input logic s1,
                      input logic s2, input bit drop_en);
    int n = c_eight ? 8 : 7;
    rxl = 1'b0;
    wait_clk(BIT);
    if (drop_en) en = 1'b0;
    for (int i = 0; i < n; i++) begin
      rxl = c_msb ? d[n-1-i] : d[i];
      wait_clk(BIT);
    end
    if (c_pen || c_mp) begin
      rxl = ext;
      wait_clk(BIT);
    end
    rxl = s1;
    wait_clk(24);
    if (expect_rx) begin
      check("R8 full set within first stop", int'(rx_full), 1);
      check("R10 idle low in first stop", int'(bus_idle), 0);
    end
    wait_clk(BIT - 24);
    if (c_two) begin
      rxl = s2;
      wait_clk(8);
      if (expect_rx) begin
        check("R8 full before second stop sample", int'(rx_full), 1);
        check("R10 idle low in second stop", int'(bus_idle), 0);
        check("R7 first stop error only", int'(frame_err), int'(!s1));
      end
      wait_clk(BIT - 8);
    end
    rxl = 1'b1;
  endtask

  task automatic expect_frame(input string tag, input logic [7:0] d, input logic ext,
                              input logic s1, input logic s2);
    logic pe;
    wait_clk(12);
    pe = c_pen && !c_mp && (ext != good_par(d));
    check({tag, " R3 R4 data"}, int'(rx_data), int'(masked(d)));
    check({tag, " R8 full"}, int'(rx_full), 1);
    check({tag, " R5 parity_err"}, int'(parity_err), int'(pe));
    check({tag, " R7 frame_err"}, int'(frame_err), int'(!s1 || (c_two && !s2)));
    check({tag, " R6 addr_bit"}, int'(addr_bit), int'(c_mp && ext));
    check({tag, " R10 idle after stop"}, int'(bus_idle), 1);
  endtask

  task automatic do_read();
    rd = 1'b1;
    wait_clk(1);
    rd = 1'b0;
    wait_clk(1);
    check("R9 read clears full", int'(rx_full), 0);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    // R1 reset state
    check("R1 data", int'(rx_data), 0);
    check("R1 full", int'(rx_full), 0);
    check("R1 errors", int'({parity_err, frame_err, overrun, addr_bit}), 0);
    check("R1 idle", int'(bus_idle), 1);

    // R2: short low pulse is rejected
    rxl = 1'b0;
    wait_clk(6);
    rxl = 1'b1;
    wait_clk(60);
    check("R2 glitch no full", int'(rx_full), 0);
    check("R2 glitch idle kept", int'(bus_idle), 1);

    // Sweep every format setting with two words each
    for (int cfg = 0; cfg < 64; cfg++) begin
      {c_msb, c_two, c_mp, c_odd, c_pen, c_eight} = 6'(cfg);
      for (int k = 0; k < 2; k++) begin
        logic [7:0] d = 8'(cfg * 53 + 17);
        logic ext;
        if (k == 1) d = ~d;
        ext = c_mp ? logic'(cfg[0] ^ k[0]) : good_par(d);
        send(d, ext, 1'b1, 1'b1, 1'b0);
        expect_frame("sweep", d, ext, 1'b1, 1'b1);
        do_read();
      end
    end

    // R5: wrong parity bit, even and odd
    {c_msb, c_two, c_mp, c_odd, c_pen, c_eight} = 6'b000011;
    send(8'h3C, ~good_par(8'h3C), 1'b1, 1'b1, 1'b0);
    expect_frame("R5 bad even", 8'h3C, ~good_par(8'h3C), 1'b1, 1'b1);
    do_read();
    c_odd = 1'b1;
    send(8'h81, ~good_par(8'h81), 1'b1, 1'b1, 1'b0);
    expect_frame("R5 bad odd", 8'h81, ~good_par(8'h81), 1'b1, 1'b1);
    do_read();

    // R7: low first stop, then low second stop, two-stop format
    {c_msb, c_two, c_mp, c_odd, c_pen, c_eight} = 6'b010001;
    send(8'h5A, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_frame("R7 stop1 low", 8'h5A, 1'b0, 1'b0, 1'b1);
    do_read();
    send(8'hA7, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_frame("R7 stop2 low", 8'hA7, 1'b0, 1'b1, 1'b0);
    do_read();
    c_two = 1'b0;
    send(8'h0F, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_frame("R7 single stop low", 8'h0F, 1'b0, 1'b0, 1'b1);
    do_read();

    // R9: overrun, then read clears it
    send(8'h11, 1'b0, 1'b1, 1'b1, 1'b0);
    expect_frame("R9 first", 8'h11, 1'b0, 1'b1, 1'b1);
    check("R9 no overrun yet", int'(overrun), 0);
    send(8'hE2, 1'b0, 1'b1, 1'b1, 1'b0);
    expect_frame("R9 second", 8'hE2, 1'b0, 1'b1, 1'b1);
    check("R9 overrun set", int'(overrun), 1);
    do_read();
    check("R9 overrun cleared", int'(overrun), 0);

    // R11: disable mid-frame, frame still stored; next frame ignored
    send(8'h6B, 1'b0, 1'b1, 1'b1, 1'b1);
    expect_frame("R11 finish", 8'h6B, 1'b0, 1'b1, 1'b1);
    do_read();
    expect_rx = 1'b0;
    send(8'h99, 1'b0, 1'b1, 1'b1, 1'b0);
    wait_clk(12);
    check("R11 no new frame", int'(rx_full), 0);
    check("R11 idle kept", int'(bus_idle), 1);
    check("R11 data kept", int'(rx_data), 8'h6B);
    expect_rx = 1'b1;
    en = 1'b1;
    send(8'hC4, 1'b0, 1'b1, 1'b1, 1'b0);
    expect_frame("R11 re-enabled", 8'hC4, 1'b0, 1'b1, 1'b1);
    do_read();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule